// File: doc/BRIEF.md
# Guest Interrupt Delivery Gate

This block sits beside a processor core and decides, every clock cycle, what happens to interrupts while a guest context runs. The host supplies a control word for the guest. One bit of it picks the policy for physical interrupt lines. When the bit is set, any raised line forces an exit back to the host. When it is clear, the lines pass straight through to the guest. The host can also load a virtual interrupt into a one-entry slot, which holds a vector and a priority. That interrupt reaches the guest when the guest's task-priority threshold and its own interrupt-enable allow it. A global interrupt flag, cleared and set by the host, holds off every kind of interrupt handling while it is clear. This protects host critical regions.

A three-state controller tracks the context. The states are `ST_HOST` (host code runs), `ST_GUEST` (a guest runs) and `ST_EXIT` (a one-cycle exit pulse to the host). There are four transitions:
- enter: `ST_HOST` to `ST_GUEST` while `guest_mode` is high.
- leave: `ST_GUEST` to `ST_HOST` when `guest_mode` drops.
- intercept: `ST_GUEST` to `ST_EXIT` on an intercepted physical interrupt.
- return: `ST_EXIT` to `ST_HOST`, always, after one cycle.

On an exit the block records the raised lines for the host, and it puts a fixed exit code on its output.

Top module: `guest_irq_gate`

## Requirements
- R1: After reset the controller is in `ST_HOST`, `gif_o` is 1, `vint_pending` is 0, and `exit_req`, `exit_code`, `vint_ack`, `vint_vector_out`, `guest_phys_irq` and `exit_irq_snap` are all 0.
- R2: `in_guest` rises one cycle after `guest_mode` is high in `ST_HOST`. It falls one cycle after `guest_mode` is low in `ST_GUEST`.
- R3: Suppose `in_guest` = 1, `guest_mode` = 1, the global flag is set, `intercept_en` = 1 and any `phys_irq` bit is 1. Then on the next cycle `exit_req` is 1 for exactly one cycle and `exit_code` is 8'h60 (0 otherwise). `exit_irq_snap` holds the `phys_irq` value of the deciding cycle until the next exit. The cycle after the pulse, `in_guest` is 0.
- R4: With `intercept_en` = 0, in the guest state with `guest_mode` = 1 and the global flag set, `guest_phys_irq` equals the previous cycle's `phys_irq`. In every other case it is 0, and no exit is taken.
- R5: `gif_clr` clears the global flag on the next cycle and `gif_set` sets it. When both are high, clear wins. While the flag is clear, no exit, no forwarding and no virtual delivery occur.
- R6: A loaded virtual interrupt is delivered only when its priority is strictly greater than `vint_tpr` and `guest_if` = 1.
- R7: When an intercept exit and a virtual delivery would both happen in the same cycle, the exit is taken and `vint_pending` stays 1.
- R8: On delivery, `vint_ack` pulses for one cycle and `vint_vector_out` shows the stored vector. `vint_pending` drops in that same cycle.
- R9: `vint_set` loads the slot (vector, priority, pending = 1) only in `ST_HOST`. In any other state it has no effect.
- R10: Virtual delivery works under both policies, with `intercept_en` = 1 and with `intercept_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| guest_mode | input | 1 | Host requests guest execution |
| phys_irq | input | N_IRQ | Physical interrupt request lines |
| intercept_en | input | 1 | Policy bit: 1 = physical interrupts exit to host |
| guest_if | input | 1 | Guest's own interrupt-enable |
| vint_tpr | input | PRIO_W | Guest task-priority threshold |
| vint_set | input | 1 | Load the virtual interrupt slot |
| vint_vector_in | input | VEC_W | Vector to load |
| vint_prio_in | input | PRIO_W | Priority to load |
| gif_set | input | 1 | Set the global interrupt flag |
| gif_clr | input | 1 | Clear the global interrupt flag |
| gif_o | output | 1 | Global interrupt flag |
| in_guest | output | 1 | Controller is in the guest state |
| exit_req | output | 1 | One-cycle exit-to-host pulse |
| exit_code | output | 8 | Exit cause code during the pulse |
| exit_irq_snap | output | N_IRQ | Lines raised at the last exit |
| vint_pending | output | 1 | Virtual interrupt slot is pending |
| vint_ack | output | 1 | Virtual interrupt delivered |
| vint_vector_out | output | VEC_W | Vector of the last delivery |
| guest_phys_irq | output | N_IRQ | Physical lines forwarded to the guest |

## Verification
Directed sequences cover four cases:
- Priority against threshold: equal values versus one step above. This separates a strict compare from a non-strict one.
- Exit versus delivery: a physical line and a ready virtual interrupt arrive together. This shows which of the two wins.
- Flag clear and load in guest state: loading the slot while the guest runs and holding the flag clear show that those inputs are ignored.
- Both policies: delivery is run once with interception on and once with it off.

Seeded random traffic then mixes entries, leaves, sparse interrupt lines, flag toggles and priority values every cycle. A cycle model built from the requirements predicts every output, which catches wrong state transitions and timing slips by one cycle.

// File: rtl/gid_pkg.sv
`timescale 1ns/1ps
package gid_pkg;
    typedef enum logic [1:0] {
        ST_HOST  = 2'd0,
        ST_GUEST = 2'd1,
        ST_EXIT  = 2'd2
    } gid_state_e;

    localparam logic [7:0] EXIT_CODE_INTR = 8'h60;
endpackage

// File: rtl/gid_gif_reg.sv
`timescale 1ns/1ps
module gid_gif_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic gif_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gif_o <= 1'b1;
        else if (clr_i)  gif_o <= 1'b0;
        else if (set_i)  gif_o <= 1'b1;
    end

    AST_GIF_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !gif_o); // R5
endmodule

// File: rtl/gid_vint_slot.sv
`timescale 1ns/1ps
module gid_vint_slot #(
    parameter int VEC_W  = 8,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0] tpr_i,
    input  logic              guest_if_i,
    input  logic              consume_i,
    output logic              pending_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              ready_o
);
    logic [PRIO_W-1:0] prio_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_o <= 1'b0;
            vec_o     <= '0;
            prio_q    <= '0;
        end else if (load_i) begin
            pending_o <= 1'b1;
            vec_o     <= vec_i;
            prio_q    <= prio_i;
        end else if (consume_i) begin
            pending_o <= 1'b0;
        end
    end

    always_comb ready_o = pending_o && guest_if_i && (prio_q > tpr_i);

    AST_RISE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> $past(load_i)); // R9
endmodule

// File: rtl/gid_ctrl_fsm.sv
`timescale 1ns/1ps
module gid_ctrl_fsm
    import gid_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             guest_mode_i,
    input  logic             gif_i,
    input  logic             intercept_en_i,
    input  logic [N_IRQ-1:0] phys_irq_i,
    input  logic             vint_ready_i,
    output gid_state_e       state_o,
    output logic             take_exit_o,
    output logic             deliver_o,
    output logic             direct_o
);
    gid_state_e state_d;
    logic       live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_o <= ST_HOST;
        else        state_o <= state_d;
    end

    always_comb begin
        live        = (state_o == ST_GUEST) && guest_mode_i && gif_i;
        take_exit_o = live && intercept_en_i && (|phys_irq_i);
        deliver_o   = live && vint_ready_i && !take_exit_o;
        direct_o    = live && !intercept_en_i;
        state_d     = state_o;
        unique case (state_o)
            ST_HOST:  if (guest_mode_i) state_d = ST_GUEST;
            ST_GUEST: begin
                if (!guest_mode_i)    state_d = ST_HOST;
                else if (take_exit_o) state_d = ST_EXIT;
            end
            ST_EXIT:  state_d = ST_HOST;
            default:  state_d = ST_HOST;
        endcase
    end

    AST_EXIT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_EXIT) |=> (state_o == ST_HOST)); // R3
endmodule

// File: rtl/guest_irq_gate.sv
`timescale 1ns/1ps
module guest_irq_gate
    import gid_pkg::*;
#(
    parameter int         N_IRQ     = 8,
    parameter int         VEC_W     = 8,
    parameter int         PRIO_W    = 4,
    parameter logic [7:0] EXIT_CODE = EXIT_CODE_INTR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guest_mode,
    input  logic [N_IRQ-1:0]  phys_irq,
    input  logic              intercept_en,
    input  logic              guest_if,
    input  logic [PRIO_W-1:0] vint_tpr,
    input  logic              vint_set,
    input  logic [VEC_W-1:0]  vint_vector_in,
    input  logic [PRIO_W-1:0] vint_prio_in,
    input  logic              gif_set,
    input  logic              gif_clr,
    output logic              gif_o,
    output logic              in_guest,
    output logic              exit_req,
    output logic [7:0]        exit_code,
    output logic [N_IRQ-1:0]  exit_irq_snap,
    output logic              vint_pending,
    output logic              vint_ack,
    output logic [VEC_W-1:0]  vint_vector_out,
    output logic [N_IRQ-1:0]  guest_phys_irq
);
    gid_state_e       state;
    logic             take_exit, deliver, direct, ready, load;
    logic [VEC_W-1:0] slot_vec;

    gid_gif_reg u_gif (
        .clk(clk), .rst_n(rst_n), .set_i(gif_set), .clr_i(gif_clr), .gif_o(gif_o)
    );

    assign load = vint_set && (state == ST_HOST);

    gid_vint_slot #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .load_i(load), .vec_i(vint_vector_in),
        .prio_i(vint_prio_in), .tpr_i(vint_tpr), .guest_if_i(guest_if),
        .consume_i(deliver), .pending_o(vint_pending), .vec_o(slot_vec),
        .ready_o(ready)
    );

    gid_ctrl_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk(clk), .rst_n(rst_n), .guest_mode_i(guest_mode), .gif_i(gif_o),
        .intercept_en_i(intercept_en), .phys_irq_i(phys_irq),
        .vint_ready_i(ready), .state_o(state), .take_exit_o(take_exit),
        .deliver_o(deliver), .direct_o(direct)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vint_ack        <= 1'b0;
            vint_vector_out <= '0;
            guest_phys_irq  <= '0;
            exit_irq_snap   <= '0;
        end else begin
            vint_ack       <= deliver;
            guest_phys_irq <= direct ? phys_irq : '0;
            if (deliver)   vint_vector_out <= slot_vec;
            if (take_exit) exit_irq_snap   <= phys_irq;
        end
    end

    always_comb begin
        in_guest  = (state == ST_GUEST);
        exit_req  = (state == ST_EXIT);
        exit_code = exit_req ? EXIT_CODE : 8'h00;
    end

    AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !exit_req); // R3
    AST_EXIT_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> (exit_code == EXIT_CODE)); // R3
    AST_ACK_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        vint_ack |-> !vint_pending); // R8
    AST_EXIT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(exit_req && vint_ack)); // R7
    AST_FWD_NEEDS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (guest_phys_irq != '0) |-> $past(!intercept_en && gif_o)); // R4
endmodule

// File: tb/sim_guest_irq_gate.sv
`timescale 1ns/1ps
module sim_guest_irq_gate;
    localparam int N = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic gm = 0, ien = 0, gie = 0, vset = 0, gset = 0, gclr = 0;
    logic [N-1:0] irq = '0;
    logic [3:0] tpr = '0, prio = '0;
    logic [7:0] vec = '0;
    logic gif_o, in_guest, exit_req, vint_pending, vint_ack;
    logic [7:0] exit_code, vint_vector_out;
    logic [N-1:0] exit_irq_snap, guest_phys_irq;
    int checks = 0, errors = 0;

    // reference model state
    int m_st; logic m_gif, m_pend, m_ack; logic [7:0] m_vec, m_vout; logic [3:0] m_prio;
    logic [N-1:0] m_gphys, m_snap;

    always #5 clk = ~clk;

    guest_irq_gate u0 (
        .clk(clk), .rst_n(rst_n), .guest_mode(gm), .phys_irq(irq),
        .intercept_en(ien), .guest_if(gie), .vint_tpr(tpr), .vint_set(vset),
        .vint_vector_in(vec), .vint_prio_in(prio), .gif_set(gset), .gif_clr(gclr),
        .gif_o(gif_o), .in_guest(in_guest), .exit_req(exit_req), .exit_code(exit_code),
        .exit_irq_snap(exit_irq_snap), .vint_pending(vint_pending), .vint_ack(vint_ack),
        .vint_vector_out(vint_vector_out), .guest_phys_irq(guest_phys_irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_gif = 1; m_pend = 0; m_ack = 0; m_vec = 0; m_vout = 0;
        m_prio = 0; m_gphys = 0; m_snap = 0;
    endtask

    task automatic model_step();
        logic live, take, dlv;
        live = (m_st == 1) && gm && m_gif;
        take = live && ien && (irq != 0);
        dlv  = live && m_pend && gie && (m_prio > tpr) && !take;
        m_ack = dlv;
        m_gphys = (live && !ien) ? irq : '0;
        if (dlv) m_vout = m_vec;
        if (take) m_snap = irq;
        if (vset && m_st == 0) begin m_pend = 1; m_vec = vec; m_prio = prio; end
        else if (dlv) m_pend = 0;
        if (gclr) m_gif = 0; else if (gset) m_gif = 1;
        case (m_st)
            0: m_st = gm ? 1 : 0;
            1: m_st = !gm ? 0 : (take ? 2 : 1);
            default: m_st = 0;
        endcase
    endtask

    task automatic compare_all();
        chk("R2", "in_guest", in_guest, m_st == 1);
        chk("R3", "exit_req", exit_req, m_st == 2);
        chk("R3", "exit_code", exit_code, (m_st == 2) ? 8'h60 : 8'h00);
        chk("R3", "exit_irq_snap", exit_irq_snap, m_snap);
        chk("R4", "guest_phys_irq", guest_phys_irq, m_gphys);
        chk("R5", "gif_o", gif_o, m_gif);
        chk("R9", "vint_pending", vint_pending, m_pend);
        chk("R8", "vint_ack", vint_ack, m_ack);
        chk("R8", "vint_vector_out", vint_vector_out, m_vout);
    endtask

    task automatic tick();
        @(posedge clk); #1 model_step();
        @(negedge clk); compare_all();
        vset = 0; gset = 0; gclr = 0;
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "in_guest", in_guest, 0); chk("R1", "gif_o", gif_o, 1);
        chk("R1", "vint_pending", vint_pending, 0); chk("R1", "exit_req", exit_req, 0);
        chk("R1", "exit_code", exit_code, 0); chk("R1", "vint_ack", vint_ack, 0);
        chk("R1", "guest_phys_irq", guest_phys_irq, 0); chk("R1", "exit_irq_snap", exit_irq_snap, 0);
        rst_n = 1;

        // R10: delivery with interception on
        ien = 1; gie = 1; tpr = 3; vset = 1; vec = 8'h41; prio = 5; tick();
        chk("R9", "pending after host load", vint_pending, 1);
        gm = 1; tick();
        tick();
        chk("R10", "ack with intercept_en=1", vint_ack, 1);
        chk("R10", "vector", vint_vector_out, 8'h41);
        chk("R8", "pending cleared with ack", vint_pending, 0);
        tick(); chk("R8", "ack is a pulse", vint_ack, 0);

        // R9: load while in guest is ignored
        vset = 1; vec = 8'h99; prio = 15; tick();
        chk("R9", "load in guest ignored", vint_pending, 0);

        // R6: equal priority blocked, one above delivered, guest_if gates
        gm = 0; tick();
        vset = 1; vec = 8'h22; prio = 3; tpr = 3; tick();
        gm = 1; tick(); tick(); tick();
        chk("R6", "equal priority held", vint_ack, 0);
        chk("R6", "still pending", vint_pending, 1);
        gie = 0; tpr = 2; tick(); tick();
        chk("R6", "guest_if=0 blocks", vint_ack, 0);
        gie = 1; tick();
        chk("R6", "delivered above tpr", vint_ack, 1);
        chk("R6", "vector", vint_vector_out, 8'h22);

        // R7: exit beats delivery
        gm = 0; tick();
        vset = 1; vec = 8'h33; prio = 9; tpr = 0; tick();
        gm = 1; tick();
        irq = 8'h04; tick(); irq = 0;
        chk("R7", "exit taken", exit_req, 1);
        chk("R7", "no ack", vint_ack, 0);
        chk("R7", "stays pending", vint_pending, 1);
        chk("R3", "snap", exit_irq_snap, 8'h04);
        tick(); chk("R3", "back to host", in_guest, 0);

        // R5: global flag clear holds everything off; clear beats set
        gm = 0; gclr = 1; gset = 1; tick();
        chk("R5", "clear wins", gif_o, 0);
        gm = 1; tick(); irq = 8'h81; tick(); tick(); irq = 0;
        chk("R5", "no exit while flag clear", exit_req, 0);
        chk("R5", "no delivery while flag clear", vint_pending, 1);
        gset = 1; tick(); tick();
        chk("R10", "delivery after flag set", vint_ack, 1);

        // R4 / R10: direct policy
        ien = 0; irq = 8'h10; tick(); irq = 0;
        chk("R4", "forwarded", guest_phys_irq, 8'h10);
        chk("R4", "no exit", exit_req, 0);

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            gm   = ($urandom % 8) != 0;
            irq  = (($urandom % 5) == 0) ? N'($urandom) : '0;
            ien  = ($urandom % 2) != 0;
            gie  = ($urandom % 4) != 0;
            tpr  = 4'($urandom);
            vset = ($urandom % 3) == 0;
            vec  = 8'($urandom);
            prio = 4'($urandom);
            gclr = ($urandom % 25) == 0;
            gset = ($urandom % 8) == 0;
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule